// File: doc/BRIEF.md
# Virtual NIC Register Decoder

This block sits between a host register bus and a network interface that presents several virtual interface instances to software. Every request carries an address. The low byte of the address selects a register, and the bits above it select a virtual instance. The block looks up the register's width and access permission. It rejects any access it cannot honour and answers it with an error pulse. Accepted accesses read or update a small set of shared control registers. Accepted writes to an instance's receive-post or transmit-post register produce a one-cycle strobe for that instance.

Reads of the interrupt status register clear it, and interrupt sources arriving in the same cycle are kept. The read-only size, count and station-address registers return elaboration parameters. The per-instance completion registers return status words supplied by the datapath.

Top module: `vnic_reg_decode`

## Requirements
- R1: A request sampled with `req_valid` high at a clock edge is answered at the next edge: `rsp_valid`, `rsp_err`, `rsp_rdata` and the post strobes hold the result for exactly that one cycle. After reset all outputs are low or zero.
- R2: The register offset is `req_addr[7:0]` and the instance index is `req_addr[ADDR_W-1:8]`. Any access whose index is not less than the instance count (minimum 1) is an error. In-range indices all reach the same shared registers.
- R3: 32-bit registers (`req_wide`=0) are decoded by offset. Read/write: 0x00 config, 0x0c interrupt mask, 0x10 rx copy limit, 0x14 tx copy limit, 0x18 rx batch limit, 0x28 rx mark, 0x2c tx mark. Read-only: 0x08 interrupt status, 0x1c instance count, 0x20 rx buffer size, 0x24 tx buffer size. Write-only: 0x04 command, which has no stored effect. A written value is returned by a read in the next cycle. 32-bit reads zero-extend.
- R4: 64-bit registers (`req_wide`=1) are decoded by offset. Write-only: 0x30 rx post and 0x48 tx post. Read-only: 0x38 rx done, 0x40 rx wait, 0x50 tx done, 0x58 tx wait, 0x60 station address.
- R5: An access whose `req_wide` does not match the register's width is an error.
- R6: A read of a write-only register or a write to a read-only register is an error.
- R7: Offsets that name no register are errors. This covers 0x68 and above, offsets below 0x30 that are not multiples of 4, and offsets from 0x30 to 0x67 that are not multiples of 8.
- R8: An error response has `rsp_err`=1 and `rsp_rdata`=0. The erroneous access changes no register, raises no strobe and clears no status.
- R9: Interrupt status bits are set by `irq_set` pulses. An accepted status read returns the bits held before the read and clears them, except for bits set in the same cycle.
- R10: After reset the interrupt mask reads 0x125, with bit 0 rx packet, bit 2 rx high, bit 5 tx low and bit 8 soft set.
- R11: A config write with both bit 12 (zero copy) and bit 11 (delayed copy) set is an error and leaves config unchanged. Other values, including bit 5 (virtual addressing), are stored.
- R12: An accepted write to rx post (or tx post) of instance i raises bit i of `rx_post_stb` (or `tx_post_stb`) alone for one cycle, with `post_data` equal to the written value.
- R13: Instance count reads the configured count. The buffer sizes and station address read their parameters. Rx done and rx wait read slice i of `rx_done_stat`, and tx done and tx wait read slice i of `tx_done_stat`, for instance i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Instance index above an 8-bit register offset |
| req_wdata | input | 64 | Write data |
| irq_set | input | 9 | Interrupt source pulses |
| rx_done_stat | input | VIF_COUNT*64 | Per-instance receive completion words |
| tx_done_stat | input | VIF_COUNT*64 | Per-instance transmit completion words |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 64 | Read data, zero on error or write |
| rx_post_stb | output | VIF_COUNT | Per-instance receive post strobe |
| tx_post_stb | output | VIF_COUNT | Per-instance transmit post strobe |
| post_data | output | 64 | Value carried with the post strobes |

## Verification
Every result of this block falls due one edge after its request: the response, the strobe, the register update and the status clear. A status bit set by `irq_set` becomes readable one request later. The bench drives each request on a falling edge and steps its model at that same moment. At the next falling edge it compares the DUT against the model's prediction for that cycle, so a write followed at once by a read checks that the update is visible without a gap. Idle cycles are compared too, so a stray strobe or response cannot hide.

// File: rtl/vnic_regs_pkg.sv
`timescale 1ns/1ps
package vnic_regs_pkg;
  localparam int OFS_W     = 8;
  localparam int DATA_W    = 64;
  localparam int IRQ_W     = 9;
  localparam int NUM_RW    = 7;
  localparam int RW_SLOT_W = 3;

  // interrupt source positions
  localparam int IRQ_RX_PKT  = 0;
  localparam int IRQ_RX_HIGH = 2;
  localparam int IRQ_TX_LOW  = 5;
  localparam int IRQ_SOFT    = 8;
  localparam logic [31:0] IMASK_RESET = (32'd1 << IRQ_RX_PKT) | (32'd1 << IRQ_RX_HIGH)
                                      | (32'd1 << IRQ_TX_LOW) | (32'd1 << IRQ_SOFT);

  // config bit positions
  localparam int CFG_VADDR = 5;
  localparam int CFG_DELAY = 11;
  localparam int CFG_ZCOPY = 12;

  typedef enum logic [4:0] {
    RID_CFG, RID_CMD, RID_ISTAT, RID_IMASK, RID_RXCOPY, RID_TXCOPY, RID_RXBATCH,
    RID_VCOUNT, RID_RXFSIZE, RID_TXFSIZE, RID_RXMARK, RID_TXMARK,
    RID_RXPOST, RID_RXDONE, RID_RXWAIT, RID_TXPOST, RID_TXDONE, RID_TXWAIT,
    RID_MAC, RID_NONE
  } reg_id_e;

  typedef struct packed {
    reg_id_e id;
    logic    wide;
    logic    rd_ok;
    logic    wr_ok;
  } reg_attr_t;

  function automatic logic is_rw(reg_id_e id);
    return (id == RID_CFG) || (id == RID_IMASK) || (id == RID_RXCOPY) ||
           (id == RID_TXCOPY) || (id == RID_RXBATCH) || (id == RID_RXMARK) ||
           (id == RID_TXMARK);
  endfunction

  function automatic logic [RW_SLOT_W-1:0] rw_index(reg_id_e id);
    case (id)
      RID_IMASK:   return 3'd1;
      RID_RXCOPY:  return 3'd2;
      RID_TXCOPY:  return 3'd3;
      RID_RXBATCH: return 3'd4;
      RID_RXMARK:  return 3'd5;
      RID_TXMARK:  return 3'd6;
      default:     return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/vnic_addr_split.sv
`timescale 1ns/1ps
module vnic_addr_split
  import vnic_regs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int VIF_COUNT = 3
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic [OFS_W-1:0]        ofs,
  output logic [ADDR_W-OFS_W-1:0] idx,
  output logic                    idx_bad
);
  localparam int IDX_W = ADDR_W - OFS_W;
  localparam int NVIF  = (VIF_COUNT < 1) ? 1 : VIF_COUNT;

  assign ofs     = addr[OFS_W-1:0];
  assign idx     = addr[ADDR_W-1:OFS_W];
  assign idx_bad = ({{(32-IDX_W){1'b0}}, idx} >= 32'(NVIF));
endmodule

// File: rtl/vnic_reg_attr.sv
`timescale 1ns/1ps
module vnic_reg_attr
  import vnic_regs_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output reg_attr_t        attr
);
  function automatic reg_attr_t mk(reg_id_e id, logic w, logic r, logic wr);
    return '{id: id, wide: w, rd_ok: r, wr_ok: wr};
  endfunction

  always_comb begin
    case (ofs)
      8'h00:   attr = mk(RID_CFG,     1'b0, 1'b1, 1'b1);
      8'h04:   attr = mk(RID_CMD,     1'b0, 1'b0, 1'b1);
      8'h08:   attr = mk(RID_ISTAT,   1'b0, 1'b1, 1'b0);
      8'h0c:   attr = mk(RID_IMASK,   1'b0, 1'b1, 1'b1);
      8'h10:   attr = mk(RID_RXCOPY,  1'b0, 1'b1, 1'b1);
      8'h14:   attr = mk(RID_TXCOPY,  1'b0, 1'b1, 1'b1);
      8'h18:   attr = mk(RID_RXBATCH, 1'b0, 1'b1, 1'b1);
      8'h1c:   attr = mk(RID_VCOUNT,  1'b0, 1'b1, 1'b0);
      8'h20:   attr = mk(RID_RXFSIZE, 1'b0, 1'b1, 1'b0);
      8'h24:   attr = mk(RID_TXFSIZE, 1'b0, 1'b1, 1'b0);
      8'h28:   attr = mk(RID_RXMARK,  1'b0, 1'b1, 1'b1);
      8'h2c:   attr = mk(RID_TXMARK,  1'b0, 1'b1, 1'b1);
      8'h30:   attr = mk(RID_RXPOST,  1'b1, 1'b0, 1'b1);
      8'h38:   attr = mk(RID_RXDONE,  1'b1, 1'b1, 1'b0);
      8'h40:   attr = mk(RID_RXWAIT,  1'b1, 1'b1, 1'b0);
      8'h48:   attr = mk(RID_TXPOST,  1'b1, 1'b0, 1'b1);
      8'h50:   attr = mk(RID_TXDONE,  1'b1, 1'b1, 1'b0);
      8'h58:   attr = mk(RID_TXWAIT,  1'b1, 1'b1, 1'b0);
      8'h60:   attr = mk(RID_MAC,     1'b1, 1'b1, 1'b0);
      default: attr = mk(RID_NONE,    1'b0, 1'b0, 1'b0);
    endcase
  end
endmodule

// File: rtl/vnic_csr_file.sv
`timescale 1ns/1ps
module vnic_csr_file
  import vnic_regs_pkg::*;
#(
  parameter int          VIF_COUNT     = 3,
  parameter int          IDX_W         = 4,
  parameter logic [31:0] CFG_INIT      = 32'h0,
  parameter logic [31:0] RX_COPY_INIT  = 32'd1514,
  parameter logic [31:0] TX_COPY_INIT  = 32'd16384,
  parameter logic [31:0] RX_BATCH_INIT = 32'd10,
  parameter logic [31:0] RX_MARK_INIT  = 32'h0006_0000,
  parameter logic [31:0] TX_MARK_INIT  = 32'h0000_4000,
  parameter logic [31:0] RX_FIFO_BYTES = 32'h0008_0000,
  parameter logic [31:0] TX_FIFO_BYTES = 32'h0002_0000,
  parameter logic [63:0] MAC_ADDR      = 64'h0000_0200_1234_5678
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [RW_SLOT_W-1:0]   wr_slot,
  input  logic [31:0]            wr_val,
  input  logic                   stat_clr,
  input  logic [IRQ_W-1:0]       irq_set,
  input  reg_id_e                rd_id,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [VIF_COUNT*64-1:0] rx_done_stat,
  input  logic [VIF_COUNT*64-1:0] tx_done_stat,
  output logic [63:0]            rd_val
);
  localparam int NVIF = (VIF_COUNT < 1) ? 1 : VIF_COUNT;

  function automatic logic [31:0] slot_init(int s);
    case (s)
      0:       return CFG_INIT;
      1:       return IMASK_RESET;
      2:       return RX_COPY_INIT;
      3:       return TX_COPY_INIT;
      4:       return RX_BATCH_INIT;
      5:       return RX_MARK_INIT;
      default: return TX_MARK_INIT;
    endcase
  endfunction

  logic [31:0] rw_val [NUM_RW];

  for (genvar s = 0; s < NUM_RW; s++) begin : g_slot
    localparam logic [31:0] INIT = slot_init(s);
    logic        en;
    logic [31:0] q;
    assign en = wr_en && (wr_slot == RW_SLOT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= INIT;
      else if (en) q <= wr_val;
    end
    assign rw_val[s] = q;
  end

  logic [IRQ_W-1:0] istat_q, istat_d;

  always_comb istat_d = (stat_clr ? '0 : istat_q) | irq_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) istat_q <= '0;
    else        istat_q <= istat_d;
  end

  int sel;
  always_comb begin
    sel = (int'(rd_idx) < VIF_COUNT) ? int'(rd_idx) : 0;
    case (rd_id)
      RID_CFG:     rd_val = {32'h0, rw_val[0]};
      RID_IMASK:   rd_val = {32'h0, rw_val[1]};
      RID_RXCOPY:  rd_val = {32'h0, rw_val[2]};
      RID_TXCOPY:  rd_val = {32'h0, rw_val[3]};
      RID_RXBATCH: rd_val = {32'h0, rw_val[4]};
      RID_RXMARK:  rd_val = {32'h0, rw_val[5]};
      RID_TXMARK:  rd_val = {32'h0, rw_val[6]};
      RID_ISTAT:   rd_val = {{(64-IRQ_W){1'b0}}, istat_q};
      RID_VCOUNT:  rd_val = {32'h0, 32'(NVIF)};
      RID_RXFSIZE: rd_val = {32'h0, RX_FIFO_BYTES};
      RID_TXFSIZE: rd_val = {32'h0, TX_FIFO_BYTES};
      RID_RXDONE,
      RID_RXWAIT:  rd_val = rx_done_stat[sel*64 +: 64];
      RID_TXDONE,
      RID_TXWAIT:  rd_val = tx_done_stat[sel*64 +: 64];
      RID_MAC:     rd_val = MAC_ADDR;
      default:     rd_val = '0;
    endcase
  end
endmodule

// File: rtl/vnic_reg_decode.sv
`timescale 1ns/1ps
module vnic_reg_decode
  import vnic_regs_pkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter int          VIF_COUNT     = 3,
  parameter logic [31:0] CFG_INIT      = 32'h0,
  parameter logic [31:0] RX_COPY_INIT  = 32'd1514,
  parameter logic [31:0] TX_COPY_INIT  = 32'd16384,
  parameter logic [31:0] RX_BATCH_INIT = 32'd10,
  parameter logic [31:0] RX_MARK_INIT  = 32'h0006_0000,
  parameter logic [31:0] TX_MARK_INIT  = 32'h0000_4000,
  parameter logic [31:0] RX_FIFO_BYTES = 32'h0008_0000,
  parameter logic [31:0] TX_FIFO_BYTES = 32'h0002_0000,
  parameter logic [63:0] MAC_ADDR      = 64'h0000_0200_1234_5678
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_wide,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [63:0]             req_wdata,
  input  logic [8:0]              irq_set,
  input  logic [VIF_COUNT*64-1:0] rx_done_stat,
  input  logic [VIF_COUNT*64-1:0] tx_done_stat,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [63:0]             rsp_rdata,
  output logic [VIF_COUNT-1:0]    rx_post_stb,
  output logic [VIF_COUNT-1:0]    tx_post_stb,
  output logic [63:0]             post_data
);
  localparam int IDX_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] ofs;
  logic [IDX_W-1:0] idx;
  logic             idx_bad;
  reg_attr_t        attr;
  logic [63:0]      rd_val;

  vnic_addr_split #(.ADDR_W(ADDR_W), .VIF_COUNT(VIF_COUNT)) u_split (
    .addr(req_addr), .ofs(ofs), .idx(idx), .idx_bad(idx_bad)
  );

  vnic_reg_attr u_attr (.ofs(ofs), .attr(attr));

  // access classification
  logic size_bad, dir_bad, cfg_bad, acc_err, do_wr, do_rd;
  always_comb begin
    size_bad = (attr.wide != req_wide);
    dir_bad  = req_write ? !attr.wr_ok : !attr.rd_ok;
    cfg_bad  = req_write && (attr.id == RID_CFG) &&
               req_wdata[CFG_ZCOPY] && req_wdata[CFG_DELAY];
    acc_err  = idx_bad || (attr.id == RID_NONE) || size_bad || dir_bad || cfg_bad;
    do_wr    = req_valid && !acc_err && req_write;
    do_rd    = req_valid && !acc_err && !req_write;
  end

  vnic_csr_file #(
    .VIF_COUNT(VIF_COUNT), .IDX_W(IDX_W), .CFG_INIT(CFG_INIT),
    .RX_COPY_INIT(RX_COPY_INIT), .TX_COPY_INIT(TX_COPY_INIT),
    .RX_BATCH_INIT(RX_BATCH_INIT), .RX_MARK_INIT(RX_MARK_INIT),
    .TX_MARK_INIT(TX_MARK_INIT), .RX_FIFO_BYTES(RX_FIFO_BYTES),
    .TX_FIFO_BYTES(TX_FIFO_BYTES), .MAC_ADDR(MAC_ADDR)
  ) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(do_wr && is_rw(attr.id)), .wr_slot(rw_index(attr.id)),
    .wr_val(req_wdata[31:0]),
    .stat_clr(do_rd && (attr.id == RID_ISTAT)), .irq_set(irq_set),
    .rd_id(attr.id), .rd_idx(idx),
    .rx_done_stat(rx_done_stat), .tx_done_stat(tx_done_stat),
    .rd_val(rd_val)
  );

  // next state of the response and strobes
  logic [VIF_COUNT-1:0] rx_stb_d, tx_stb_d;
  logic                 post_en;
  logic [63:0]          rdata_d;

  for (genvar v = 0; v < VIF_COUNT; v++) begin : g_vif
    assign rx_stb_d[v] = do_wr && (attr.id == RID_RXPOST) && (idx == IDX_W'(v));
    assign tx_stb_d[v] = do_wr && (attr.id == RID_TXPOST) && (idx == IDX_W'(v));
  end

  always_comb begin
    post_en = do_wr && ((attr.id == RID_RXPOST) || (attr.id == RID_TXPOST));
    rdata_d = do_rd ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= '0;
      rx_post_stb <= '0;
      tx_post_stb <= '0;
      post_data   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_err     <= req_valid && acc_err;
      rsp_rdata   <= rdata_d;
      rx_post_stb <= rx_stb_d;
      tx_post_stb <= tx_stb_d;
      if (post_en) post_data <= req_wdata;
    end
  end
endmodule

// File: rtl/vnic_reg_decode_chk.sv
`timescale 1ns/1ps
module vnic_reg_decode_chk #(
  parameter int ADDR_W    = 12,
  parameter int VIF_COUNT = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 req_wide,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [1:0]           cfg_pair,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic [63:0]          rsp_rdata,
  input logic [VIF_COUNT-1:0] rx_post_stb,
  input logic [VIF_COUNT-1:0] tx_post_stb
);
  localparam int NVIF = (VIF_COUNT < 1) ? 1 : VIF_COUNT;

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  assert_bad_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (32'(req_addr[ADDR_W-1:8]) >= NVIF) |=> rsp_err);

  assert_narrow_region_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wide && (req_addr[7:0] < 8'h30) |=> rsp_err);

  assert_unused_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_addr[7:0] >= 8'h68) |=> rsp_err);

  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && (rsp_rdata == 64'h0));

  assert_err_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rx_post_stb == '0) && (tx_post_stb == '0));

  assert_cfg_conflict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !req_wide && (req_addr[7:0] == 8'h00) && (cfg_pair == 2'b11)
    |=> rsp_err);

  assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({rx_post_stb, tx_post_stb}) <= 1));

  assert_strobe_with_ok_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|{rx_post_stb, tx_post_stb}) |-> rsp_valid && !rsp_err);
endmodule

bind vnic_reg_decode vnic_reg_decode_chk #(.ADDR_W(ADDR_W), .VIF_COUNT(VIF_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wide(req_wide), .req_addr(req_addr), .cfg_pair(req_wdata[12:11]),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .rx_post_stb(rx_post_stb), .tx_post_stb(tx_post_stb)
);

// File: tb/vnic_reg_decode_bench.sv
`timescale 1ns/1ps
module vnic_reg_decode_bench;
  localparam int          AW   = 12;
  localparam int          NV   = 3;
  localparam logic [31:0] RXC  = 32'd1514;
  localparam logic [31:0] TXC  = 32'd16384;
  localparam logic [31:0] RXB  = 32'd10;
  localparam logic [31:0] RXM  = 32'h0006_0000;
  localparam logic [31:0] TXM  = 32'h0000_4000;
  localparam logic [31:0] RXF  = 32'h0008_0000;
  localparam logic [31:0] TXF  = 32'h0002_0000;
  localparam logic [63:0] MAC  = 64'h0000_0200_1234_5678;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_write, req_wide;
  logic [AW-1:0]     req_addr;
  logic [63:0]       req_wdata;
  logic [8:0]        irq_set;
  logic [NV*64-1:0]  rx_done_stat, tx_done_stat;
  logic              rsp_valid, rsp_err;
  logic [63:0]       rsp_rdata, post_data;
  logic [NV-1:0]     rx_post_stb, tx_post_stb;

  vnic_reg_decode #(
    .ADDR_W(AW), .VIF_COUNT(NV), .CFG_INIT(32'h0), .RX_COPY_INIT(RXC),
    .TX_COPY_INIT(TXC), .RX_BATCH_INIT(RXB), .RX_MARK_INIT(RXM),
    .TX_MARK_INIT(TXM), .RX_FIFO_BYTES(RXF), .TX_FIFO_BYTES(TXF), .MAC_ADDR(MAC)
  ) u_vnic_reg_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .irq_set(irq_set), .rx_done_stat(rx_done_stat), .tx_done_stat(tx_done_stat),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .rx_post_stb(rx_post_stb), .tx_post_stb(tx_post_stb), .post_data(post_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // ---- behavioural model state ----
  logic [31:0] m_cfg, m_mask, m_rxc, m_txc, m_rxb, m_rxm, m_txm;
  logic [8:0]  m_istat;
  logic        e_valid = 1'b0, e_err = 1'b0;
  logic [63:0] e_rdata = '0, e_data = '0;
  logic [NV-1:0] e_rx = '0, e_tx = '0;
  string       e_tag = "R1";

  function automatic logic [63:0] stat_rx(int i);
    return 64'hD0E0_0000_0000_1000 + 64'(i);
  endfunction
  function automatic logic [63:0] stat_tx(int i);
    return 64'h7F00_0000_0000_2000 + 64'(i);
  endfunction

  // width in bytes of the register at an offset, 0 if none
  function automatic int mdl_width(int ofs);
    case (ofs)
      'h00, 'h04, 'h08, 'h0c, 'h10, 'h14, 'h18, 'h1c,
      'h20, 'h24, 'h28, 'h2c: return 4;
      'h30, 'h38, 'h40, 'h48, 'h50, 'h58, 'h60: return 8;
      default: return 0;
    endcase
  endfunction

  // 0 read/write, 1 read-only, 2 write-only
  function automatic int mdl_perm(int ofs);
    case (ofs)
      'h08, 'h1c, 'h20, 'h24, 'h38, 'h40, 'h50, 'h58, 'h60: return 1;
      'h04, 'h30, 'h48: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] mdl_read(int ofs, int idx);
    case (ofs)
      'h00: return {32'h0, m_cfg};
      'h08: return {55'h0, m_istat};
      'h0c: return {32'h0, m_mask};
      'h10: return {32'h0, m_rxc};
      'h14: return {32'h0, m_txc};
      'h18: return {32'h0, m_rxb};
      'h1c: return 64'(NV);
      'h20: return {32'h0, RXF};
      'h24: return {32'h0, TXF};
      'h28: return {32'h0, m_rxm};
      'h2c: return {32'h0, m_txm};
      'h38, 'h40: return stat_rx(idx);
      'h50, 'h58: return stat_tx(idx);
      'h60: return MAC;
      default: return 64'h0;
    endcase
  endfunction

  task automatic compare();
    logic bad;
    n_checks++;
    bad = (rsp_valid !== e_valid) || (rsp_err !== e_err) || (rsp_rdata !== e_rdata) ||
          (rx_post_stb !== e_rx) || (tx_post_stb !== e_tx) ||
          (((e_rx | e_tx) != '0) && (post_data !== e_data));
    if (bad) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b e=%0b d=%h rx=%b tx=%b pd=%h expected v=%0b e=%0b d=%h rx=%b tx=%b pd=%h",
               e_tag, rsp_valid, rsp_err, rsp_rdata, rx_post_stb, tx_post_stb, post_data,
               e_valid, e_err, e_rdata, e_rx, e_tx, e_data);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic wide, input int idx,
                     input int ofs, input logic [63:0] wd, input logic [8:0] irq,
                     input string tag);
    int width, perm;
    logic bad;
    logic [8:0] nxt;
    @(negedge clk);
    compare();
    req_valid = v; req_write = w; req_wide = wide;
    req_addr  = AW'(idx * 256 + ofs);
    req_wdata = wd; irq_set = irq;
    e_tag = tag; e_valid = v; e_err = 1'b0; e_rdata = '0; e_rx = '0; e_tx = '0;
    nxt = m_istat;
    if (v) begin
      width = mdl_width(ofs);
      perm  = mdl_perm(ofs);
      bad = (idx >= NV) || (width == 0) || ((wide ? 8 : 4) != width) ||
            (w && perm == 1) || (!w && perm == 2) ||
            (w && ofs == 0 && wd[12] && wd[11]);
      if (bad) e_err = 1'b1;
      else if (!w) begin
        e_rdata = mdl_read(ofs, idx);
        if (ofs == 'h08) nxt = '0;
      end else begin
        case (ofs)
          'h00: m_cfg  = wd[31:0];
          'h0c: m_mask = wd[31:0];
          'h10: m_rxc  = wd[31:0];
          'h14: m_txc  = wd[31:0];
          'h18: m_rxb  = wd[31:0];
          'h28: m_rxm  = wd[31:0];
          'h2c: m_txm  = wd[31:0];
          'h30: begin e_rx[idx] = 1'b1; e_data = wd; end
          'h48: begin e_tx[idx] = 1'b1; e_data = wd; end
          default: ;
        endcase
      end
    end
    m_istat = nxt | irq;
  endtask

  task automatic rd(input logic wide, input int idx, input int ofs, input string tag);
    cyc(1'b1, 1'b0, wide, idx, ofs, 64'h0, 9'h0, tag);
  endtask
  task automatic wr(input logic wide, input int idx, input int ofs, input logic [63:0] wd,
                    input string tag);
    cyc(1'b1, 1'b1, wide, idx, ofs, wd, 9'h0, tag);
  endtask
  task automatic idle(input logic [8:0] irq, input string tag);
    cyc(1'b0, 1'b0, 1'b0, 0, 0, 64'h0, irq, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual run still active, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < NV; i++) begin
      rx_done_stat[i*64 +: 64] = stat_rx(i);
      tx_done_stat[i*64 +: 64] = stat_tx(i);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    req_addr = '0; req_wdata = '0; irq_set = '0;
    m_cfg = 32'h0; m_mask = 32'h125; m_rxc = RXC; m_txc = TXC; m_rxb = RXB;
    m_rxm = RXM; m_txm = TXM; m_istat = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_checks++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== '0 ||
        rx_post_stb !== '0 || tx_post_stb !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual v=%0b e=%0b d=%h expected all zero", rsp_valid, rsp_err, rsp_rdata);
    end
    rst_n = 1'b1;
    idle(9'h0, "R1 idle after reset");

    // R3/R10/R13: narrow registers at instance 0
    rd(1'b0, 0, 'h00, "R3 config reset read");
    rd(1'b0, 0, 'h0c, "R10 mask reset 0x125");
    rd(1'b0, 0, 'h10, "R3 rx copy");
    rd(1'b0, 0, 'h14, "R3 tx copy");
    rd(1'b0, 0, 'h18, "R3 rx batch");
    rd(1'b0, 0, 'h1c, "R13 instance count");
    rd(1'b0, 0, 'h20, "R13 rx size");
    rd(1'b0, 0, 'h24, "R13 tx size");
    rd(1'b0, 0, 'h28, "R3 rx mark");
    rd(1'b0, 0, 'h2c, "R3 tx mark");
    rd(1'b0, 0, 'h08, "R9 status empty");
    // R4/R13: wide registers per instance
    rd(1'b1, 1, 'h38, "R13 rx done inst1");
    rd(1'b1, 2, 'h40, "R13 rx wait inst2");
    rd(1'b1, 0, 'h50, "R13 tx done inst0");
    rd(1'b1, 2, 'h58, "R13 tx wait inst2");
    rd(1'b1, 1, 'h60, "R4 station address");
    // R6: direction errors
    rd(1'b0, 0, 'h04, "R6 read write-only command");
    rd(1'b1, 0, 'h30, "R6 read rx post");
    wr(1'b0, 0, 'h1c, 64'h5, "R6 write instance count");
    wr(1'b0, 0, 'h08, 64'h1, "R6 write status");
    wr(1'b1, 0, 'h60, 64'h1, "R6 write station address");
    wr(1'b0, 0, 'h04, 64'h77, "R3 command write accepted");
    // R5: size mismatch
    rd(1'b1, 0, 'h00, "R5 wide read of config");
    rd(1'b0, 0, 'h60, "R5 narrow read of address");
    wr(1'b0, 1, 'h30, 64'h1234, "R5 narrow rx post");
    wr(1'b1, 0, 'h28, 64'h1, "R5 wide write of mark");
    rd(1'b0, 0, 'h28, "R8 mark unchanged");
    // R7: unused offsets
    rd(1'b0, 0, 'h68, "R7 offset 0x68");
    rd(1'b1, 0, 'hf8, "R7 offset 0xf8");
    rd(1'b1, 0, 'h34, "R7 offset 0x34");
    rd(1'b0, 0, 'h02, "R7 offset 0x02");
    // R2: index range
    rd(1'b0, 3, 'h00, "R2 index equal to count");
    rd(1'b0, 15, 'h0c, "R2 top index");
    wr(1'b1, 3, 'h30, 64'h9, "R2 post to missing instance");
    rd(1'b0, 2, 'h0c, "R2 shared reg via inst2");
    // R11: config conflicts
    wr(1'b0, 0, 'h00, 64'h1820, "R11 zero+delay copy rejected");
    rd(1'b0, 0, 'h00, "R11 config unchanged");
    wr(1'b0, 1, 'h00, 64'h1020, "R11 zero copy + vaddr");
    rd(1'b0, 0, 'h00, "R11 config readback");
    wr(1'b0, 0, 'h00, 64'h0800, "R11 delay copy alone");
    rd(1'b0, 2, 'h00, "R11 config readback 2");
    // R3: writes visible the next cycle
    wr(1'b0, 0, 'h0c, 64'hFFFF_FFFF_0000_01FF, "R3 mask write");
    rd(1'b0, 0, 'h0c, "R3 mask readback");
    wr(1'b0, 0, 'h28, 64'hABCD_1234, "R3 rx mark write");
    rd(1'b0, 0, 'h28, "R3 rx mark readback");
    wr(1'b0, 0, 'h10, 64'h800, "R3 rx copy write");
    wr(1'b0, 0, 'h2c, 64'h55, "R3 tx mark write");
    rd(1'b0, 0, 'h10, "R3 rx copy readback");
    rd(1'b0, 0, 'h2c, "R3 tx mark readback");
    // R12: post strobes
    wr(1'b1, 0, 'h30, 64'h1000_0000_0000_0040, "R12 rx post inst0");
    wr(1'b1, 1, 'h30, 64'h2000_0000_0000_0080, "R12 rx post inst1");
    wr(1'b1, 2, 'h48, 64'h3000_0000_0000_00c0, "R12 tx post inst2");
    idle(9'h0, "R12 strobe ends");
    wr(1'b1, 2, 'h30, 64'h4444, "R12 rx post inst2");
    wr(1'b1, 0, 'h48, 64'h5555, "R12 tx post inst0");
    idle(9'h0, "R12 strobe ends 2");
    // R9: status set and clear-on-read
    idle(9'h021, "R9 set bits");
    idle(9'h000, "R9 idle");
    rd(1'b1, 0, 'h08, "R8 errored status read keeps bits");
    cyc(1'b1, 1'b0, 1'b0, 0, 'h08, 64'h0, 9'h100, "R9 read clears, same-cycle set kept");
    rd(1'b0, 0, 'h08, "R9 second read");
    rd(1'b0, 0, 'h08, "R9 third read empty");
    idle(9'h004, "R9 set again");
    rd(1'b0, 3, 'h08, "R8 out-of-range status read keeps bits");
    rd(1'b0, 1, 'h08, "R9 read via inst1");
    idle(9'h0, "R1 final");
    idle(9'h0, "R1 final idle");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule